// File: doc/BRIEF.md
# Soft-Start Reference Ramp Sequencer

This block generates the digital reference code that a switching regulator follows while it starts up. Once a single qualified-enable input is high, it waits a fixed number of switching periods with the reference at zero. It then raises the reference as a staircase until it reaches a programmed target code. The staircase uses large steps for the first part of the ramp and half-size steps for the rest. The average slope is the same in both parts. During the same early part of the ramp, a small offset code for the remote-sense amplifier counts down from full value to zero.

A one-cycle `tick` marks each switching period, and nothing advances without it. A digitized feedback code is compared with the ramping reference so that a pre-charged output is not discharged. The power stage stays high-impedance until the reference first reaches the feedback level. From then on it stays enabled. If the output is pre-charged above the target, the drivers turn on when soft-start ends. Dropping the enable returns everything to idle.

Top module: `soft_start_seq`

## Requirements
- R1: On the first clock edge with `en_ok` high, the sequence starts. For the next DELAY_TICKS ticks (default 64), `ref_code` stays 0, `ofs_code` stays at OFS_INIT and `drv_en` and `ss_done` stay low.
- R2: In the coarse phase, `ref_code` rises by COARSE_STEP codes on every COARSE_PERIOD-th tick. This phase covers the first COARSE_TICKS ticks after the delay (default: 2 codes every 32 ticks for 640 ticks, one code = 12.5 mV).
- R3: After the coarse phase, `ref_code` rises by FINE_STEP codes on every FINE_PERIOD-th tick (default: 1 code every 16 ticks). This keeps the same average slope.
- R4: At the start of the ramp, `ofs_code` equals OFS_INIT. It falls by one on every OFS_PERIOD-th ramp tick, reaches 0 after COARSE_TICKS ramp ticks, and stays at 0.
- R5: Clock edges without `tick` leave `ref_code`, `ofs_code` and `ss_done` unchanged.
- R6: `ref_code` never steps past `target`. The step that would reach or cross it lands exactly on `target`, and `ss_done` goes high on that same tick. After that the reference holds and `drv_en` stays high.
- R7: During the ramp, `drv_en` goes high combinationally in the first cycle in which `ref_code` >= `fb_code`, and not earlier.
- R8: Once `drv_en` is high, it stays high while `en_ok` stays high, whatever `fb_code` does afterwards.
- R9: If `fb_code` is above `target`, `drv_en` stays low for the whole ramp and rises together with `ss_done`.
- R10: A clock edge with `en_ok` low returns the block to idle: `ref_code`=0, `ofs_code`=OFS_INIT, `drv_en`=0 and `ss_done`=0. A later enable restarts the sequence from the delay.
- R11: A `target` of 0 completes soft-start on the last delay tick, with `ss_done` and `drv_en` both high.
- R12: While `rst_n` is low, the block is in the idle state of R10.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle pulse per switching period |
| en_ok | input | 1 | Combined, qualified enable |
| target | input | REF_W | Programmed final reference code |
| fb_code | input | REF_W | Digitized feedback level |
| ref_code | output | REF_W | Ramping reference code |
| ofs_code | output | OFS_W | Remote-sense offset code |
| drv_en | output | 1 | Power-stage enable; low means high-impedance |
| ss_done | output | 1 | Soft-start complete |

## Verification
The bench builds the block with a 4-tick delay, a 16-tick coarse phase of 2 codes every 4 ticks, 1-code fine steps every 2 ticks, and an offset of 4 that decays every 4 ticks. These values keep the same slope relations as the defaults. They let a full ramp to target 20 run in about 45 cycles. The coarse-to-fine switch, the offset reaching zero, the clamp on an odd target, pre-charge gating both below and above the target, stalled ticks and a restart after a mid-ramp disable all fit into a few hundred cycles.

// File: rtl/ss_pkg.sv
package ss_pkg;

   typedef enum logic [1:0] {
      SS_IDLE = 2'd0,
      SS_WAIT = 2'd1,
      SS_RAMP = 2'd2,
      SS_HOLD = 2'd3
   } ss_state_e;

   function automatic int ss_max4(input int a, input int b, input int c, input int d);
      int m;
      m = a;
      if (b > m) m = b;
      if (c > m) m = c;
      if (d > m) m = d;
      return m;
   endfunction

endpackage

// File: rtl/ss_tick_div.sv
// Modulo tick counter: pulses wrap on the advance that completes a period.
module ss_tick_div #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             adv,
   input  logic [CNT_W-1:0] last,
   output logic             wrap
);

   logic [CNT_W-1:0] cnt_q;

   assign wrap = adv && !clr && (cnt_q == last);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (clr || wrap) begin
         cnt_q <= '0;
      end else if (adv) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

endmodule

// File: rtl/ss_ref_step.sv
// Next staircase value with clamp at the target code.
module ss_ref_step #(
   parameter int REF_W       = 8,
   parameter int COARSE_STEP = 2,
   parameter int FINE_STEP   = 1
) (
   input  logic [REF_W-1:0] cur,
   input  logic [REF_W-1:0] target,
   input  logic             coarse,
   output logic [REF_W-1:0] nxt,
   output logic             hit
);

   localparam int SUM_W = REF_W + 1;

   logic [SUM_W-1:0] inc;
   logic [SUM_W-1:0] sum;

   generate
      if (COARSE_STEP == FINE_STEP) begin : g_one_step
         assign inc = SUM_W'(COARSE_STEP);
      end else begin : g_two_step
         assign inc = coarse ? SUM_W'(COARSE_STEP) : SUM_W'(FINE_STEP);
      end
   endgenerate

   always_comb begin
      sum = {1'b0, cur} + inc;
      if (sum >= {1'b0, target}) begin
         nxt = target;
         hit = 1'b1;
      end else begin
         nxt = sum[REF_W-1:0];
         hit = 1'b0;
      end
   end

endmodule

// File: rtl/soft_start_seq.sv
module soft_start_seq #(
   parameter int REF_W         = 8,
   parameter int DELAY_TICKS   = 64,
   parameter int COARSE_TICKS  = 640,
   parameter int COARSE_PERIOD = 32,
   parameter int COARSE_STEP   = 2,
   parameter int FINE_PERIOD   = 16,
   parameter int FINE_STEP     = 1,
   parameter int OFS_INIT      = 8,
   parameter int OFS_PERIOD    = 80,
   localparam int OFS_W        = $clog2(OFS_INIT + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             en_ok,
   input  logic [REF_W-1:0] target,
   input  logic [REF_W-1:0] fb_code,
   output logic [REF_W-1:0] ref_code,
   output logic [OFS_W-1:0] ofs_code,
   output logic             drv_en,
   output logic             ss_done
);

   import ss_pkg::*;

   localparam int DIV_MAX = ss_max4(DELAY_TICKS, COARSE_PERIOD, FINE_PERIOD, OFS_PERIOD);
   localparam int DIV_W   = $clog2(DIV_MAX + 1);
   localparam int RC_W    = $clog2(COARSE_TICKS + 1);

   initial begin : g_param_chk
      if (REF_W < 2 || DELAY_TICKS < 1 || COARSE_PERIOD < 1 || FINE_PERIOD < 1 || OFS_PERIOD < 1)
         $fatal(1, "soft_start_seq: width or period too small");
      if (COARSE_TICKS % COARSE_PERIOD != 0)
         $fatal(1, "soft_start_seq: coarse phase must hold whole steps");
      if (COARSE_STEP * FINE_PERIOD != FINE_STEP * COARSE_PERIOD)
         $fatal(1, "soft_start_seq: coarse and fine slopes differ");
      if (OFS_INIT * OFS_PERIOD != COARSE_TICKS)
         $fatal(1, "soft_start_seq: offset must decay over the coarse phase");
   end

   ss_state_e        state_q;
   logic [REF_W-1:0] ref_q;
   logic [OFS_W-1:0] ofs_q;
   logic [RC_W-1:0]  rcnt_q;
   logic             drv_lat_q;

   logic in_wait, in_ramp, in_hold, running;
   logic coarse;
   logic dly_wrap, step_wrap, ofs_wrap;
   logic [REF_W-1:0] ref_nxt;
   logic ref_hit;
   logic [DIV_W-1:0] step_last;

   assign in_wait = (state_q == SS_WAIT);
   assign in_ramp = (state_q == SS_RAMP);
   assign in_hold = (state_q == SS_HOLD);
   assign running = in_ramp || in_hold;
   assign coarse  = (rcnt_q < RC_W'(COARSE_TICKS));

   generate
      if (COARSE_PERIOD == FINE_PERIOD) begin : g_same_period
         assign step_last = DIV_W'(COARSE_PERIOD - 1);
      end else begin : g_split_period
         assign step_last = coarse ? DIV_W'(COARSE_PERIOD - 1) : DIV_W'(FINE_PERIOD - 1);
      end
   endgenerate

   ss_tick_div #(.CNT_W(DIV_W)) u_dly_div (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (!en_ok || !in_wait),
      .adv   (tick && in_wait),
      .last  (DIV_W'(DELAY_TICKS - 1)),
      .wrap  (dly_wrap)
   );

   ss_tick_div #(.CNT_W(DIV_W)) u_step_div (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (!en_ok || !in_ramp),
      .adv   (tick && in_ramp),
      .last  (step_last),
      .wrap  (step_wrap)
   );

   ss_tick_div #(.CNT_W(DIV_W)) u_ofs_div (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (!en_ok || !running),
      .adv   (tick && running && (ofs_q != '0)),
      .last  (DIV_W'(OFS_PERIOD - 1)),
      .wrap  (ofs_wrap)
   );

   ss_ref_step #(
      .REF_W       (REF_W),
      .COARSE_STEP (COARSE_STEP),
      .FINE_STEP   (FINE_STEP)
   ) u_step (
      .cur    (ref_q),
      .target (target),
      .coarse (coarse),
      .nxt    (ref_nxt),
      .hit    (ref_hit)
   );

   // Driver gate: combinational rise on the first qualifying cycle, then latched.
   assign drv_en = in_hold || drv_lat_q || (in_ramp && (ref_q >= fb_code));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= SS_IDLE;
         ref_q     <= '0;
         ofs_q     <= OFS_W'(OFS_INIT);
         rcnt_q    <= '0;
         drv_lat_q <= 1'b0;
      end else if (!en_ok) begin
         state_q   <= SS_IDLE;
         ref_q     <= '0;
         ofs_q     <= OFS_W'(OFS_INIT);
         rcnt_q    <= '0;
         drv_lat_q <= 1'b0;
      end else begin
         drv_lat_q <= running ? drv_en : 1'b0;
         if (ofs_wrap) begin
            ofs_q <= ofs_q - 1'b1;
         end
         case (state_q)
            SS_IDLE: begin
               state_q <= SS_WAIT;
            end
            SS_WAIT: begin
               if (dly_wrap) begin
                  state_q <= (target == '0) ? SS_HOLD : SS_RAMP;
               end
            end
            SS_RAMP: begin
               if (tick && coarse) begin
                  rcnt_q <= rcnt_q + 1'b1;
               end
               if (step_wrap) begin
                  ref_q <= ref_nxt;
                  if (ref_hit) begin
                     state_q <= SS_HOLD;
                  end
               end
            end
            default: begin
               state_q <= SS_HOLD;
            end
         endcase
      end
   end

   assign ref_code = ref_q;
   assign ofs_code = ofs_q;
   assign ss_done  = in_hold;

endmodule

// File: rtl/ss_seq_chk.sv
module ss_seq_chk #(
   parameter int REF_W       = 8,
   parameter int COARSE_STEP = 2,
   parameter int OFS_INIT    = 8,
   localparam int OFS_W      = $clog2(OFS_INIT + 1)
) (
   input logic             clk,
   input logic             rst_n,
   input logic             tick,
   input logic             en_ok,
   input logic [REF_W-1:0] target,
   input logic [REF_W-1:0] fb_code,
   input logic [REF_W-1:0] ref_code,
   input logic [OFS_W-1:0] ofs_code,
   input logic             drv_en,
   input logic             ss_done
);

   assert_idle_on_disable_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !en_ok |=> (ref_code == '0 && ofs_code == OFS_W'(OFS_INIT) && !drv_en && !ss_done));

   assert_ref_monotonic_R2: assert property (@(posedge clk) disable iff (!rst_n)
      en_ok |=> (ref_code >= $past(ref_code)));

   assert_step_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
      en_ok |=> ((ref_code - $past(ref_code)) <= REF_W'(COARSE_STEP)));

   assert_hold_without_tick_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (en_ok && !tick) |=> ($stable(ref_code) && $stable(ofs_code)));

   assert_ofs_nonincreasing_R4: assert property (@(posedge clk) disable iff (!rst_n)
      en_ok |=> (ofs_code <= $past(ofs_code)));

   assert_done_lands_on_target_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (en_ok && $stable(target) && $rose(ss_done)) |-> (ref_code == target));

   assert_done_drives_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ss_done |-> drv_en);

   assert_drv_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (drv_en && en_ok) |=> drv_en);

endmodule

bind soft_start_seq ss_seq_chk #(
   .REF_W       (REF_W),
   .COARSE_STEP (COARSE_STEP),
   .OFS_INIT    (OFS_INIT)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .tick     (tick),
   .en_ok    (en_ok),
   .target   (target),
   .fb_code  (fb_code),
   .ref_code (ref_code),
   .ofs_code (ofs_code),
   .drv_en   (drv_en),
   .ss_done  (ss_done)
);

// File: tb/sim_soft_start_seq.sv
module sim_soft_start_seq;

   localparam int REF_W = 8;
   localparam int DLY   = 4;
   localparam int CT    = 16;
   localparam int CP    = 4;
   localparam int CS    = 2;
   localparam int FP    = 2;
   localparam int FS    = 1;
   localparam int OI    = 4;
   localparam int OP    = 4;
   localparam int OFS_W = $clog2(OI + 1);

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic tick = 1'b0;
   logic en_ok = 1'b0;
   logic [REF_W-1:0] target = '0;
   logic [REF_W-1:0] fb_code = '0;
   logic [REF_W-1:0] ref_code;
   logic [OFS_W-1:0] ofs_code;
   logic drv_en;
   logic ss_done;

   int checks = 0;
   int errors = 0;
   bit active = 0;
   int n = 0;
   bit lat = 0;
   bit finished = 0;

   always #5 clk = ~clk;

   soft_start_seq #(
      .REF_W(REF_W), .DELAY_TICKS(DLY), .COARSE_TICKS(CT), .COARSE_PERIOD(CP),
      .COARSE_STEP(CS), .FINE_PERIOD(FP), .FINE_STEP(FS), .OFS_INIT(OI), .OFS_PERIOD(OP)
   ) u0 (
      .clk(clk), .rst_n(rst_n), .tick(tick), .en_ok(en_ok), .target(target),
      .fb_code(fb_code), .ref_code(ref_code), .ofs_code(ofs_code),
      .drv_en(drv_en), .ss_done(ss_done)
   );

   task automatic check(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s at n=%0d: actual=%0d expected=%0d", req, what, n, act, exp);
      end
   endtask

   function automatic int exp_ref(input int j);
      int r;
      if (j <= CT) r = CS * (j / CP);
      else r = CS * (CT / CP) + FS * ((j - CT) / FP);
      if (r > int'(target)) r = int'(target);
      return r;
   endfunction

   task automatic check_all(input string req);
      int er, eo, ed, ev, j;
      if (!active || n < DLY) begin
         er = 0; eo = OI; ed = 0; ev = 0;
      end else begin
         j  = n - DLY;
         er = exp_ref(j);
         eo = (j / OP >= OI) ? 0 : OI - j / OP;
         ed = (er == int'(target)) ? 1 : 0;
         ev = (ed == 1 || lat || er >= int'(fb_code)) ? 1 : 0;
      end
      check(req, "ref_code", int'(ref_code), er);
      check(req, "ofs_code", int'(ofs_code), eo);
      check(req, "ss_done", int'(ss_done), ed);
      check(req, "drv_en", int'(drv_en), ev);
      lat = (active && n >= DLY) ? (ev == 1) : 1'b0;
   endtask

   task automatic cycle(input logic t, input string req);
      tick = t;
      @(posedge clk);
      if (t && active) n++;
      active = en_ok;
      if (!en_ok) begin
         n = 0;
         lat = 0;
      end
      @(negedge clk);
      check_all(req);
   endtask

   task automatic start(input int tgt, input int fb);
      target  = REF_W'(tgt);
      fb_code = REF_W'(fb);
      en_ok   = 1'b1;
   endtask

   task automatic stop_and_check(input string req);
      en_ok = 1'b0;
      cycle(1'b1, req);
   endtask

   // R12: idle outputs during and after reset, before any enable
   task automatic t_reset;
      check_all("R12");
      rst_n = 1'b1;
      cycle(1'b1, "R12");
   endtask

   // R1 delay, R2 coarse, R3 fine, R4 offset decay, R6 done, R7 drivers with fb 0
   task automatic t_full_ramp;
      start(20, 0);
      for (int i = 0; i < DLY + 1; i++) cycle(1'b1, "R1");
      for (int i = 0; i < CT - 1; i++) cycle(1'b1, "R2_R4");
      for (int i = 0; i < 26; i++) cycle(1'b1, "R3_R6");
      check("R6", "ref at target", int'(ref_code), 20);
      check("R4", "offset zero", int'(ofs_code), 0);
      stop_and_check("R10");
   endtask

   // R6: odd target inside the coarse phase is clamped, not overshot
   task automatic t_clamp;
      start(5, 0);
      for (int i = 0; i < DLY + 16; i++) cycle(1'b1, "R6");
      check("R6", "clamped ref", int'(ref_code), 5);
      stop_and_check("R10");
   endtask

   // R7 first crossing, R8 sticky after fb rises
   task automatic t_precharge;
      start(20, 10);
      for (int i = 0; i < DLY + 24; i++) cycle(1'b1, "R7");
      fb_code = REF_W'(30);
      for (int i = 0; i < 6; i++) cycle(1'b1, "R8");
      check("R8", "drv stays on", int'(drv_en), 1);
      for (int i = 0; i < 16; i++) cycle(1'b1, "R8");
      stop_and_check("R10");
   endtask

   // R9: feedback above target enables drivers only at completion
   task automatic t_above_target;
      start(20, 40);
      for (int i = 0; i < DLY + 42; i++) cycle(1'b1, "R9");
      check("R9", "drv at done", int'(drv_en), 1);
      stop_and_check("R10");
   endtask

   // R11: zero target finishes on the last delay tick
   task automatic t_zero_target;
      start(0, 5);
      for (int i = 0; i < DLY + 4; i++) cycle(1'b1, "R11");
      check("R11", "done", int'(ss_done), 1);
      stop_and_check("R10");
   endtask

   // R5: edges without tick hold everything, including across the coarse/fine boundary
   task automatic t_tick_gaps;
      start(20, 0);
      for (int i = 0; i < DLY + 7; i++) cycle(1'b1, "R5");
      for (int i = 0; i < 5; i++) cycle(1'b0, "R5");
      for (int i = 0; i < 40; i++) cycle(i[0], "R5");
      for (int i = 0; i < 20; i++) cycle(1'b1, "R5");
      stop_and_check("R10");
   endtask

   // R10: disable mid-ramp gives idle, re-enable restarts from the delay
   task automatic t_restart;
      start(20, 0);
      for (int i = 0; i < DLY + 12; i++) cycle(1'b1, "R10");
      stop_and_check("R10");
      check("R10", "ref after disable", int'(ref_code), 0);
      cycle(1'b1, "R10");
      start(12, 3);
      for (int i = 0; i < DLY + 30; i++) cycle(1'b1, "R10");
      stop_and_check("R10");
   endtask

   initial begin
      @(negedge clk);
      @(negedge clk);
      t_reset();
      t_full_ramp();
      t_clamp();
      t_precharge();
      t_above_target();
      t_zero_target();
      t_tick_gaps();
      t_restart();
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule